// File: doc/BRIEF.md
# Prioritized Alarm Event Queue

This block takes event pulses from three kinds of source: a slot-occupancy input, a group of hardware trap inputs and a set of monitor alarm flags. A host can also post a software event code through a small register port. Every source keeps its own pending bit, and events from different sources can arrive in the same cycle. A fixed-priority arbiter grants one pending source per cycle and encodes it as a byte-wide queue entry. The entries go into a shallow FIFO, and a downstream playback engine drains that FIFO with pop and flush strobes.

A software event can be released at once. It can also be held back by a watchdog timer, which counts single-cycle tick pulses of about 1 Hz up to a programmed limit. The host programs the event code early. If the timer reaches its limit, the code is released as a voice message vector.

Register map (`regAddr`):
- 0: timeout limit, 8 bits.
- 1: control; bit 0 enables the timeout.
- 2: software event code, bits 6:0. Writing this register arms the software event.

Top module: `alarm_evq`

## Requirements
- R1: After reset the queue is empty: `headValid`=0 and `queueLevel`=0. `overflowFlag` is 0.
- R2: A high cycle on an event input is one event, and it is queued as `{1'b0, code}`. The codes are: `slotOccIn` gives 1; `trapIn[i]` gives 2+i; `monAlarmIn[j]` gives 8+j.
- R3: When several events are pending, the queue takes one entry per cycle and the sources that lose stay pending. Priority runs from highest to lowest: slot input, then traps 0 to 4 in index order, then the software event, then monitor bit 0, bit 1 and upward.
- R4: With the timeout disabled, writing register 2 queues `{1'b1, code}` two clock edges after the write cycle.
- R5: With the timeout enabled, each tick advances a counter, which saturates at the limit. An armed software event is released only once the counter equals the limit.
- R6: Writing the limit, or writing 0 to the enable bit, clears the counter and cancels an armed software event.
- R7: Entries leave in the order they arrived, one per `popIn` cycle. A push and a pop in the same cycle on a full queue keep the level at the depth and set no overflow.
- R8: The queue holds 8 entries. When it is full and no pop happens, the granted event is dropped and `overflowFlag` is set. The flag stays set through later pops.
- R9: `flushIn` empties the queue and clears `overflowFlag` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotOccIn | input | 1 | Slot-occupancy event pulse |
| trapIn | input | 5 | Hardware trap event pulses |
| monAlarmIn | input | 17 | Monitor alarm event pulses |
| tickIn | input | 1 | Timeout tick enable pulse |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | 8 | Register write data |
| popIn | input | 1 | Consumer pop strobe |
| flushIn | input | 1 | Consumer queue clear |
| headValid | output | 1 | Queue holds at least one entry |
| headEntry | output | 8 | Oldest entry: bit 7 marks a software event, bits 6:0 hold the vector |
| queueLevel | output | 4 | Number of stored entries |
| overflowFlag | output | 1 | Sticky drop indicator |

## Verification
The bench builds the block with its default parameters: five traps, seventeen monitor alarms, a depth of eight and an 8-bit timeout. With up to twenty-three hardware sources firing in a single cycle, random bursts easily exceed the queue depth. This reaches both the priority ordering and the drop-with-overflow path. Small timeout limits of two and three ticks let the bench follow the saturation, release and cancellation cases tick by tick.

// File: rtl/evq_pkg.sv
package evq_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic drop;
  } qStrobe_t;
endpackage

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
#(
  parameter int NUM_TRAP = 5,
  parameter int NUM_MON  = 17,
  parameter int CODE_W   = 7,
  parameter int TMO_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                slotOccIn,
  input  logic [NUM_TRAP-1:0] trapIn,
  input  logic [NUM_MON-1:0]  monAlarmIn,
  input  logic                tickIn,
  input  logic                regWe,
  input  logic [1:0]          regAddr,
  input  logic [TMO_W-1:0]    regWdata,
  input  logic                popIn,
  input  logic                flushIn,
  input  logic                qFull,
  output qStrobe_t            strb,
  output logic [CODE_W:0]     pushEntry
);
  localparam int NSRC   = NUM_TRAP + NUM_MON + 2;
  localparam int SW_IDX = NUM_TRAP + 1;
  localparam int IDX_W  = $clog2(NSRC);

  logic [NSRC-1:0]   pend, req, grantVec;
  logic [IDX_W-1:0]  grantIdx;
  logic              anyGrant;
  logic              armed, swRelease, tmoEn;
  logic [CODE_W-1:0] swCode, swPendCode, swSel;
  logic [TMO_W-1:0]  tmoReg, tmoCnt;
  logic              wrTmo, wrCtl, wrCode, cancel;

  assign wrTmo  = regWe && (regAddr == 2'd0);
  assign wrCtl  = regWe && (regAddr == 2'd1);
  assign wrCode = regWe && (regAddr == 2'd2);
  assign cancel = wrTmo || (wrCtl && !regWdata[0]);

  assign swRelease = armed && !pend[SW_IDX] && !cancel &&
                     (!tmoEn || (tmoCnt >= tmoReg));

  // Request vector in priority order, lowest index wins
  always_comb begin
    req = pend;
    req[0] = pend[0] | slotOccIn;
    for (int i = 0; i < NUM_TRAP; i++) req[1+i] = pend[1+i] | trapIn[i];
    req[SW_IDX] = pend[SW_IDX] | swRelease;
    for (int j = 0; j < NUM_MON; j++) req[SW_IDX+1+j] = pend[SW_IDX+1+j] | monAlarmIn[j];
  end

  always_comb begin
    grantIdx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) grantIdx = IDX_W'(i);
    end
  end

  assign anyGrant = (|req) && !flushIn;
  assign grantVec = anyGrant ? (NSRC'(1) << grantIdx) : '0;
  assign swSel    = pend[SW_IDX] ? swPendCode : swCode;
  assign pushEntry = (grantIdx == IDX_W'(SW_IDX)) ? {1'b1, swSel}
                   : {1'b0, CODE_W'({1'b0, grantIdx}) + CODE_W'(1)};

  assign strb.push  = anyGrant && (!qFull || popIn);
  assign strb.drop  = anyGrant && qFull && !popIn;
  assign strb.pop   = popIn && !flushIn;
  assign strb.flush = flushIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend       <= '0;
      armed      <= 1'b0;
      swCode     <= '0;
      swPendCode <= '0;
      tmoReg     <= '0;
      tmoEn      <= 1'b0;
      tmoCnt     <= '0;
    end else begin
      pend <= req & ~grantVec;
      if (swRelease) swPendCode <= swCode;
      if (wrTmo) tmoReg <= regWdata;
      if (wrCtl) tmoEn <= regWdata[0];
      if (wrCode) swCode <= regWdata[CODE_W-1:0];
      if (cancel)         armed <= 1'b0;
      else if (wrCode)    armed <= 1'b1;
      else if (swRelease) armed <= 1'b0;
      if (cancel) tmoCnt <= '0;
      else if (tmoEn && tickIn && (tmoCnt < tmoReg)) tmoCnt <= tmoCnt + TMO_W'(1);
    end
  end

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));
  // R5
  cnt_le_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmoCnt <= tmoReg);
  // R6
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    cancel |=> (tmoCnt == '0) && !armed);
  // R8
  push_drop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.push && strb.drop));
endmodule

// File: rtl/evq_datapath.sv
module evq_datapath
  import evq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ENTRY_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  qStrobe_t           strb,
  input  logic [ENTRY_W-1:0] pushEntry,
  output logic               qFull,
  output logic               headValid,
  output logic [ENTRY_W-1:0] headEntry,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic               ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic               doPop, doPush;

  assign doPop     = strb.pop && (level != '0);
  assign doPush    = strb.push;
  assign qFull     = (level == LVL_W'(DEPTH));
  assign headValid = (level != '0);
  assign headEntry = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushEntry;
        wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + PTR_W'(1);
      end
      if (doPop) rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + PTR_W'(1);
      if (doPush && !doPop)      level <= level + LVL_W'(1);
      else if (doPop && !doPush) level <= level - LVL_W'(1);
      if (strb.drop) ovf <= 1'b1;
    end
  end

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
  // R7
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (!qFull || doPop));
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (level == '0) && !ovf);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !strb.flush) |=> ovf);
endmodule

// File: rtl/alarm_evq.sv
module alarm_evq
  import evq_pkg::*;
#(
  parameter int NUM_TRAP = 5,
  parameter int NUM_MON  = 17,
  parameter int DEPTH    = 8,
  parameter int CODE_W   = 7,
  parameter int TMO_W    = 8,
  localparam int LVL_W   = $clog2(DEPTH+1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                slotOccIn,
  input  logic [NUM_TRAP-1:0] trapIn,
  input  logic [NUM_MON-1:0]  monAlarmIn,
  input  logic                tickIn,
  input  logic                regWe,
  input  logic [1:0]          regAddr,
  input  logic [TMO_W-1:0]    regWdata,
  input  logic                popIn,
  input  logic                flushIn,
  output logic                headValid,
  output logic [CODE_W:0]     headEntry,
  output logic [LVL_W-1:0]    queueLevel,
  output logic                overflowFlag
);
  qStrobe_t          strb;
  logic [CODE_W:0]   pushEntry;
  logic              qFull;

  evq_ctrl #(.NUM_TRAP(NUM_TRAP), .NUM_MON(NUM_MON), .CODE_W(CODE_W), .TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .slotOccIn(slotOccIn), .trapIn(trapIn),
    .monAlarmIn(monAlarmIn), .tickIn(tickIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .popIn(popIn), .flushIn(flushIn), .qFull(qFull),
    .strb(strb), .pushEntry(pushEntry)
  );

  evq_datapath #(.DEPTH(DEPTH), .ENTRY_W(CODE_W+1)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pushEntry(pushEntry), .qFull(qFull),
    .headValid(headValid), .headEntry(headEntry), .level(queueLevel),
    .ovf(overflowFlag)
  );
endmodule

// File: tb/alarm_evq_tb.sv
`timescale 1ns/1ps
module alarm_evq_tb;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        slotOccIn = 0, tickIn = 0, regWe = 0, popIn = 0, flushIn = 0;
  logic [4:0]  trapIn = '0;
  logic [16:0] monAlarmIn = '0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic        headValid, overflowFlag;
  logic [7:0]  headEntry;
  logic [3:0]  queueLevel;
  int nChk = 0, nBad = 0;
  int seed = 32'h5eed;

  always #2.5 clk = ~clk;

  alarm_evq u_dut (.*);

  task automatic chk(string rq, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // bench source k: 0 slot, 1..5 traps, 6..22 monitors
  function automatic int hwCode(int k);
    if (k <= 5) return k + 1;
    return k + 2;
  endfunction

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(int a, int d);
    @(negedge clk); regWe = 1; regAddr = 2'(a); regWdata = 8'(d);
    @(negedge clk); regWe = 0;
  endtask
  task automatic tick();
    @(negedge clk); tickIn = 1; @(negedge clk); tickIn = 0;
  endtask
  task automatic pop();
    @(negedge clk); popIn = 1; @(negedge clk); popIn = 0;
  endtask
  task automatic flush();
    @(negedge clk); flushIn = 1; @(negedge clk); flushIn = 0;
  endtask
  task automatic pulseK(int k);
    @(negedge clk);
    if (k == 0) slotOccIn = 1; else if (k <= 5) trapIn[k-1] = 1; else monAlarmIn[k-6] = 1;
    @(negedge clk); slotOccIn = 0; trapIn = '0; monAlarmIn = '0;
  endtask
  task automatic popExpect(string rq, int exp);
    chk(rq, headEntry, exp);
    pop();
  endtask

  initial begin
    #(5.0 * 150000);
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    cyc(3); rstN = 1; cyc(1);
    // R1 reset state
    chk("R1 valid", headValid, 0); chk("R1 level", queueLevel, 0); chk("R1 ovf", overflowFlag, 0);

    // R2 codes
    pulseK(0); pulseK(3); pulseK(22); cyc(2);
    chk("R2 level", queueLevel, 3);
    popExpect("R2 slot", 1); popExpect("R2 trap2", 4); popExpect("R2 mon16", 24);

    // R3 priority incl. software between traps and monitors (timeout disabled)
    @(negedge clk); regWe = 1; regAddr = 2; regWdata = 8'h23;
    @(negedge clk); regWe = 0; trapIn[4] = 1; monAlarmIn[1:0] = 2'b11;
    @(negedge clk); trapIn = '0; monAlarmIn = '0;
    cyc(5);
    chk("R3 level", queueLevel, 4);
    popExpect("R3 trap4", 6); popExpect("R3 sw", 8'h80 | 8'h23);
    popExpect("R3 mon0", 8); popExpect("R3 mon1", 9);

    // R4 immediate software release
    @(negedge clk); regWe = 1; regAddr = 2; regWdata = 8'h55;
    @(negedge clk); regWe = 0;
    chk("R4 not yet", headValid, 0);
    @(negedge clk);
    chk("R4 valid", headValid, 1);
    popExpect("R4 code", 8'hD5);

    // R5 timeout release
    wr(0, 3); wr(1, 1); wr(2, 8'h11);
    tick(); tick(); cyc(3);
    chk("R5 held", headValid, 0);
    tick(); cyc(2);
    chk("R5 released", headValid, 1);
    popExpect("R5 code", 8'h91);

    // R6 cancel by limit write
    wr(0, 2); wr(2, 8'h22); tick();
    wr(0, 2); tick(); tick(); tick(); cyc(3);
    chk("R6 cancelled", headValid, 0);
    wr(2, 8'h33); cyc(2);
    chk("R6 rearm at limit", headEntry, 8'hB3);
    pop();
    // R6 cancel by disable
    wr(0, 2); wr(2, 8'h44); tick(); wr(1, 0); cyc(3);
    chk("R6 disable cancels", headValid, 0);

    // R8 overflow and stickiness
    for (int i = 0; i < 10; i++) pulseK(i);
    cyc(2);
    chk("R8 level", queueLevel, 8); chk("R8 ovf", overflowFlag, 1);
    popExpect("R8 first", 1);
    chk("R8 sticky", overflowFlag, 1);
    // R9
    flush();
    chk("R9 level", queueLevel, 0); chk("R9 ovf", overflowFlag, 0);

    // R7 push and pop together on a full queue
    for (int i = 1; i <= 8; i++) pulseK(i);
    cyc(1);
    chk("R7 full", queueLevel, 8);
    @(negedge clk); popIn = 1; monAlarmIn[5] = 1;
    @(negedge clk); popIn = 0; monAlarmIn = '0;
    chk("R7 level", queueLevel, 8); chk("R7 no ovf", overflowFlag, 0);
    for (int i = 2; i <= 8; i++) popExpect("R7 order", hwCode(i));
    popExpect("R7 last", hwCode(11));
    chk("R7 empty", headValid, 0);

    // Random simultaneous bursts: R3, R8
    for (int r = 0; r < 40; r++) begin
      logic [22:0] m;
      int n, got;
      m = 23'($urandom) & 23'($urandom);
      n = $countones(m);
      @(negedge clk); slotOccIn = m[0]; trapIn = m[5:1]; monAlarmIn = m[22:6];
      @(negedge clk); slotOccIn = 0; trapIn = '0; monAlarmIn = '0;
      cyc(28);
      chk("R8 rnd level", queueLevel, (n > 8) ? 8 : n);
      chk("R8 rnd ovf", overflowFlag, (n > 8) ? 1 : 0);
      got = 0;
      for (int k = 0; k < 23; k++) begin
        if (m[k] && got < 8) begin
          popExpect("R3 rnd order", hwCode(k));
          got++;
        end
      end
      flush();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule